// File: doc/BRIEF.md
# Data Address Range Watch Unit

This block observes a processor's data bus and compares every load or store against six address-range watchpoints. Each watchpoint has an inclusive lower and upper bound and a 2-bit trigger field that selects reads, writes, both, or neither. When an access matches an armed watchpoint and the global arm flag is set, the unit raises a one-cycle hit pulse toward the exception logic. It also records a fixed cause code, the number of the winning watchpoint and the exact offending address.

Software programs the unit through a simple indexed register port. One index holds the packed trigger word, twelve indices hold the bounds, one holds the global arm flag, and one holds the exception status. A write to the status index acknowledges the event. The access interface only observes the bus and never applies back-pressure, so it is a plain strobe with no ready signal. The register port is plain control: a write takes effect at the clock edge where `reg_we` is high, and reads are combinational from `reg_idx`.

Top module: `dwu_watch_unit`

## Requirements
- R1: After reset every register index reads zero, `exc_status` and `exc_addr` are zero and `wp_hit` is low.
- R2: Watchpoint n matches when lower(n) <= address <= upper(n). Both bounds are inclusive, so the addresses just below the lower bound and just above the upper bound do not match.
- R3: The trigger field of watchpoint n is bits [3+4n:2+4n] of the trigger word. Value 1 fires on reads only, 2 on writes only, 3 on either, and 0 leaves the watchpoint free.
- R4: No watchpoint fires unless bit 19 of the arm register (index 13) is set.
- R5: `wp_hit` goes high for exactly one cycle, in the cycle after the edge that samples a matching access strobe.
- R6: On a recorded hit, status bits 15:8 hold cause code 0x0C and bits 2:0 hold the lowest-numbered matching watchpoint.
- R7: `exc_addr` holds the exact access address, not the lower bound of the range.
- R8: The recorded status and address stay unchanged on later hits until software writes status index 14 with any value. That write clears both, and it wins over a hit at the same edge. `wp_hit` still pulses for every firing access.
- R9: An access at the same edge as a register write is compared against the values held before the write.
- R10: Clearing a trigger field stops that watchpoint from firing and leaves the arm flag set.
- R11: Register map: index 0 is the trigger word, index 1+2n is lower(n), index 2+2n is upper(n), 13 is arm, 14 is status and 15 is the read-only exception address. Reserved trigger-word bits and arm-register bits other than 19 read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Data access strobe |
| acc_addr | input | 32 | Data access address |
| acc_write | input | 1 | 1 = store, 0 = load |
| reg_we | input | 1 | Register write enable |
| reg_idx | input | 4 | Register index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` |
| wp_hit | output | 1 | One-cycle watchpoint hit pulse |
| exc_status | output | 32 | Exception status: cause 15:8, winner 2:0 |
| exc_addr | output | 32 | Captured offending address |

## Verification
The hardest cases to reach from the ports are the ones where two things happen at the same clock edge. These are a register write landing on the same edge as a matching access, and a status acknowledge landing on the same edge as a fresh hit. The bench drives both inputs at the same falling edge, so one rising edge samples them together. It then checks the pulse and the recorded status on the next falling edge. Priority among watchpoints is reached by programming overlapping ranges on non-adjacent watchpoints.

// File: rtl/dwu_pkg.sv
package dwu_pkg;
  localparam logic [7:0] CAUSE_WATCH = 8'h0C;
  localparam int         ARM_BIT     = 19;
  localparam int         FLD_BASE    = 2;
  localparam int         FLD_STRIDE  = 4;

  function automatic int fld_lsb(input int n);
    return FLD_BASE + FLD_STRIDE * n;
  endfunction

  function automatic logic [31:0] ctrl_mask(input int nwp);
    logic [31:0] m;
    m = '0;
    for (int n = 0; n < nwp; n++) m[fld_lsb(n) +: 2] = 2'b11;
    return m;
  endfunction
endpackage

// File: rtl/dwu_range_cmp.sv
module dwu_range_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [1:0]        trig,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  output logic              match
);
  logic in_range;
  logic dir_ok;
  always_comb begin
    in_range = (addr >= lo) && (addr <= hi);
    dir_ok   = is_write ? trig[1] : trig[0];
    match    = in_range && dir_ok;
  end
endmodule

// File: rtl/dwu_prio.sv
module dwu_prio #(
  parameter int N = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] win
);
  always_comb begin
    any = |req;
    win = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) win = IW'(i);
    end
  end

  // R6: the winner is a requester and no lower-numbered request exists
  always_comb begin
    if (any) begin
      p_win_lowest_r6: assert (req[win] && ((req & ((N'(1) << win) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/dwu_regfile.sv
module dwu_regfile
  import dwu_pkg::*;
#(
  parameter int NUM_WP = 6,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [IDX_W-1:0]              reg_idx,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata,
  input  logic [DATA_W-1:0]             stat_in,
  input  logic [ADDR_W-1:0]             eaddr_in,
  output logic [DATA_W-1:0]             ctrl_o,
  output logic                          arm_o,
  output logic [NUM_WP-1:0][ADDR_W-1:0] lo_o,
  output logic [NUM_WP-1:0][ADDR_W-1:0] hi_o,
  output logic                          stat_wr_o
);
  localparam int          ARM_IDX   = 2 * NUM_WP + 1;
  localparam int          STAT_IDX  = 2 * NUM_WP + 2;
  localparam int          EADDR_IDX = 2 * NUM_WP + 3;
  localparam logic [31:0] CMASK     = ctrl_mask(NUM_WP);

  logic [DATA_W-1:0] ctrl_q;
  logic              arm_q;
  logic [ADDR_W-1:0] lo_q [NUM_WP];
  logic [ADDR_W-1:0] hi_q [NUM_WP];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      arm_q  <= 1'b0;
    end else if (reg_we) begin
      if (reg_idx == IDX_W'(0))       ctrl_q <= reg_wdata & DATA_W'(CMASK);
      if (reg_idx == IDX_W'(ARM_IDX)) arm_q  <= reg_wdata[ARM_BIT];
    end
  end

  for (genvar n = 0; n < NUM_WP; n++) begin : g_bnd
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[n] <= '0;
        hi_q[n] <= '0;
      end else if (reg_we) begin
        if (reg_idx == IDX_W'(1 + 2 * n)) lo_q[n] <= reg_wdata[ADDR_W-1:0];
        if (reg_idx == IDX_W'(2 + 2 * n)) hi_q[n] <= reg_wdata[ADDR_W-1:0];
      end
    end
    assign lo_o[n] = lo_q[n];
    assign hi_o[n] = hi_q[n];
  end

  assign ctrl_o    = ctrl_q;
  assign arm_o     = arm_q;
  assign stat_wr_o = reg_we && (reg_idx == IDX_W'(STAT_IDX));

  always_comb begin
    reg_rdata = '0;
    if (reg_idx == IDX_W'(0)) reg_rdata = ctrl_q;
    for (int n = 0; n < NUM_WP; n++) begin
      if (reg_idx == IDX_W'(1 + 2 * n)) reg_rdata = DATA_W'(lo_q[n]);
      if (reg_idx == IDX_W'(2 + 2 * n)) reg_rdata = DATA_W'(hi_q[n]);
    end
    if (reg_idx == IDX_W'(ARM_IDX))   reg_rdata[ARM_BIT] = arm_q;
    if (reg_idx == IDX_W'(STAT_IDX))  reg_rdata = stat_in;
    if (reg_idx == IDX_W'(EADDR_IDX)) reg_rdata = DATA_W'(eaddr_in);
  end

  // R11: reserved trigger-word bits never hold a one
  p_ctrl_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~DATA_W'(CMASK)) == '0);
endmodule

// File: rtl/dwu_watch_unit.sv
module dwu_watch_unit
  import dwu_pkg::*;
#(
  parameter int NUM_WP = 6,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              wp_hit,
  output logic [DATA_W-1:0] exc_status,
  output logic [ADDR_W-1:0] exc_addr
);
  localparam int WIN_W = (NUM_WP > 1) ? $clog2(NUM_WP) : 1;

  logic [DATA_W-1:0]             ctrl;
  logic                          arm;
  logic [NUM_WP-1:0][ADDR_W-1:0] lo;
  logic [NUM_WP-1:0][ADDR_W-1:0] hi;
  logic                          stat_wr;
  logic [NUM_WP-1:0]             match;
  logic                          any_match;
  logic [WIN_W-1:0]              win;
  logic                          fire;

  logic              hit_q;
  logic              ev_valid_q;
  logic [WIN_W-1:0]  ev_win_q;
  logic [ADDR_W-1:0] ev_addr_q;

  dwu_regfile #(
    .NUM_WP(NUM_WP), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stat_in(exc_status), .eaddr_in(exc_addr),
    .ctrl_o(ctrl), .arm_o(arm), .lo_o(lo), .hi_o(hi), .stat_wr_o(stat_wr)
  );

  for (genvar n = 0; n < NUM_WP; n++) begin : g_cmp
    dwu_range_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .lo(lo[n]), .hi(hi[n]), .trig(ctrl[fld_lsb(n) +: 2]),
      .addr(acc_addr), .is_write(acc_write), .match(match[n])
    );
  end

  dwu_prio #(.N(NUM_WP)) u_prio (.req(match), .any(any_match), .win(win));

  assign fire = acc_valid && arm && any_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q      <= 1'b0;
      ev_valid_q <= 1'b0;
      ev_win_q   <= '0;
      ev_addr_q  <= '0;
    end else begin
      hit_q <= fire;
      if (stat_wr) begin
        ev_valid_q <= 1'b0;
        ev_win_q   <= '0;
        ev_addr_q  <= '0;
      end else if (fire && !ev_valid_q) begin
        ev_valid_q <= 1'b1;
        ev_win_q   <= win;
        ev_addr_q  <= acc_addr;
      end
    end
  end

  always_comb begin
    exc_status            = '0;
    exc_status[15:8]      = ev_valid_q ? CAUSE_WATCH : 8'h00;
    exc_status[WIN_W-1:0] = ev_win_q;
  end
  assign exc_addr = ev_addr_q;
  assign wp_hit   = hit_q;

  // R5: a pulse always follows a sampled strobe
  p_hit_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wp_hit |-> $past(acc_valid));
  // R4: a pulse requires the arm flag at the sampling edge
  p_hit_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wp_hit |-> $past(arm));
  // R6: a recorded event carries the watch cause and a valid index
  p_cause_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_status[15:8] != 8'h00) |-> (exc_status[15:8] == CAUSE_WATCH && int'(ev_win_q) < NUM_WP));
  // R8: a held event address does not move while the event stays recorded
  p_sticky_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_q && $past(ev_valid_q)) |-> $stable(exc_addr));
  // R8: an acknowledge always clears the record at the next edge
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (exc_status == '0));
endmodule

// File: tb/dwu_watch_unit_bench.sv
module dwu_watch_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        wp_hit;
  logic [31:0] exc_status;
  logic [31:0] exc_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dwu_watch_unit u_dwu_watch_unit (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wp_hit(wp_hit), .exc_status(exc_status), .exc_addr(exc_addr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = 4'(idx); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    reg_idx = 4'(idx);
    #1 d = reg_rdata;
  endtask

  // drive one access; returns with the cycle after the sampling edge visible
  task automatic access(input logic [31:0] a, input bit w);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_write = w;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [31:0] a, input bit w, input bit exp);
    access(a, w);
    check(wp_hit == exp, req, 32'(wp_hit), 32'(exp));
  endtask

  task automatic ack();
    wr(14, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < 16; i++) begin
      rd(i, d);
      check(d == 0, "R1 reg", d, 0);
    end
    check(wp_hit == 0 && exc_status == 0 && exc_addr == 0, "R1 outputs", exc_status, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); check(d == 32'h00CC_CCCC, "R11 ctrl reserved", d, 32'h00CC_CCCC);
    wr(13, 32'hFFFF_FFFF);
    rd(13, d); check(d == 32'h0008_0000, "R11 arm reserved", d, 32'h0008_0000);
    wr(5, 32'hA5A5_0005); wr(12, 32'h5A5A_000C);
    rd(5, d); check(d == 32'hA5A5_0005, "R11 lower2", d, 32'hA5A5_0005);
    rd(12, d); check(d == 32'h5A5A_000C, "R11 upper5", d, 32'h5A5A_000C);
    wr(15, 32'h1234_5678);
    rd(15, d); check(d == 0, "R11 eaddr read-only", d, 0);
    for (int i = 0; i < 14; i++) wr(i, 32'h0);
  endtask

  task automatic t_range();
    wr(5, 32'h1000); wr(6, 32'h100F);
    wr(0, 32'h3 << 10);
    wr(13, 32'h1 << 19);
    expect_hit("R2 below", 32'h0FFF, 0, 0);
    expect_hit("R2 lower edge", 32'h1000, 0, 1);
    check(exc_addr == 32'h1000, "R7 addr", exc_addr, 32'h1000);
    check(exc_status == 32'h0C02, "R6 cause/idx", exc_status, 32'h0C02);
    ack();
    expect_hit("R2 upper edge", 32'h100F, 1, 1);
    check(exc_addr == 32'h100F, "R7 exact addr", exc_addr, 32'h100F);
    ack();
    expect_hit("R2 above", 32'h1010, 1, 0);
  endtask

  task automatic t_pulse();
    expect_hit("R5 pulse high", 32'h1004, 0, 1);
    @(negedge clk);
    check(wp_hit == 0, "R5 pulse one cycle", 32'(wp_hit), 0);
    ack();
  endtask

  task automatic t_rw();
    wr(0, 32'h0); wr(1, 32'h200); wr(2, 32'h2FF);
    wr(0, 32'h1 << 2);
    expect_hit("R3 read-only read", 32'h280, 0, 1); ack();
    expect_hit("R3 read-only write", 32'h280, 1, 0);
    wr(0, 32'h2 << 2);
    expect_hit("R3 write-only write", 32'h280, 1, 1); ack();
    expect_hit("R3 write-only read", 32'h280, 0, 0);
    wr(0, 32'h0);
    expect_hit("R3 free", 32'h280, 1, 0);
  endtask

  task automatic t_enable();
    wr(0, 32'h3 << 2);
    wr(13, 32'h0);
    expect_hit("R4 disarmed", 32'h280, 1, 0);
    check(exc_status == 0, "R4 no record", exc_status, 0);
    wr(13, 32'h1 << 19);
    expect_hit("R4 armed", 32'h280, 1, 1); ack();
  endtask

  task automatic t_priority();
    wr(0, 32'h0);
    wr(3, 32'h4000); wr(4, 32'h40FF);
    wr(9, 32'h4080); wr(10, 32'h41FF);
    wr(7, 32'h5000); wr(8, 32'h5000);
    wr(0, (32'h3 << 6) | (32'h3 << 14) | (32'h3 << 18));
    expect_hit("R6 overlap", 32'h40A0, 0, 1);
    check(exc_status == 32'h0C01, "R6 lowest wins", exc_status, 32'h0C01); ack();
    expect_hit("R6 only wp4", 32'h4150, 0, 1);
    check(exc_status == 32'h0C04, "R6 idx4", exc_status, 32'h0C04); ack();
    expect_hit("R6 single-address wp3", 32'h5000, 1, 1);
    check(exc_status == 32'h0C03, "R6 idx3", exc_status, 32'h0C03); ack();
  endtask

  task automatic t_sticky();
    expect_hit("R8 first", 32'h4010, 0, 1);
    expect_hit("R8 second pulses", 32'h4150, 1, 1);
    check(exc_addr == 32'h4010, "R8 addr kept", exc_addr, 32'h4010);
    check(exc_status == 32'h0C01, "R8 status kept", exc_status, 32'h0C01);
    wr(14, 32'hFFFF_FFFF);
    check(exc_status == 0 && exc_addr == 0, "R8 ack clears", exc_addr, 0);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 32'h4020; acc_write = 1'b0;
    reg_we = 1'b1; reg_idx = 4'd14; reg_wdata = 32'h0;
    @(negedge clk);
    acc_valid = 1'b0; reg_we = 1'b0;
    check(wp_hit == 1, "R8 coincident pulse", 32'(wp_hit), 1);
    check(exc_status == 0, "R8 ack wins", exc_status, 0);
  endtask

  task automatic t_coincident();
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 32'h4020; acc_write = 1'b1;
    reg_we = 1'b1; reg_idx = 4'd0; reg_wdata = 32'h0;
    @(negedge clk);
    acc_valid = 1'b0; reg_we = 1'b0;
    check(wp_hit == 1, "R9 old ctrl used", 32'(wp_hit), 1);
    ack();
    expect_hit("R9 new ctrl after", 32'h4020, 1, 0);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 32'h4020; acc_write = 1'b1;
    reg_we = 1'b1; reg_idx = 4'd0; reg_wdata = 32'h3 << 6;
    @(negedge clk);
    acc_valid = 1'b0; reg_we = 1'b0;
    check(wp_hit == 0, "R9 enable not early", 32'(wp_hit), 0);
    expect_hit("R9 enable later", 32'h4020, 1, 1); ack();
  endtask

  task automatic t_field_clear();
    logic [31:0] d;
    wr(0, 32'h0);
    rd(13, d);
    check(d == 32'h0008_0000, "R10 arm kept", d, 32'h0008_0000);
    expect_hit("R10 cleared field", 32'h4020, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_range();
    t_pulse();
    t_rw();
    t_enable();
    t_priority();
    t_sticky();
    t_coincident();
    t_field_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule